// File: doc/BRIEF.md
# Transmit Frame Loader

This block sits between a host write port and the byte-wide transmit side of an Ethernet MAC. Software hands over a frame as 32-bit words. Every word except the final one goes to the data address. The final word goes to a separate end-of-frame address. That end-of-frame write marks the frame boundary and also starts transmission, so no length field is ever written. A 2-bit byte count travels with the end-of-frame write and says how many low-order lanes of that word carry data.

Once a frame is committed, the block pulls words from its FIFO and sends them out one byte at a time over a valid/ready byte interface. The least significant byte of each word goes first. The final byte of the frame is flagged. After the final byte, the block waits for the MAC to report the outcome. It then latches the MAC's status word and sets a sticky completion bit, which software clears by writing a one. An empty indication tells software when a new frame may be loaded. A watermark flag shows when the FIFO is three quarters full.

Top module: `tx_frame_loader`

## Requirements
- R1: While reset is asserted and right after it is released, tx_empty_o is 1 and tx_valid_o, done_o, wmark_o and tx_stat_o are all 0.
- R2: Words written with wr_last_i=0 are only stored. No byte is presented on tx_valid_o until a write with wr_last_i=1 commits the frame.
- R3: Frame bytes leave in the order the words were written. Within a word, bits 7:0 go first, then 15:8, 23:16 and 31:24.
- R4: On the end-of-frame write, wr_bytes_i gives the number of valid low-order lanes: 1, 2 or 3, with 0 meaning all 4. Unused high lanes are never sent. tx_last_o is 1 on the final byte of the frame and on no other byte.
- R5: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o, tx_data_o and tx_last_o hold their values.
- R6: tx_empty_o is 1 only when the FIFO holds no word and no frame is being sent or waiting for its outcome. It is 0 in the cycle after any accepted write, and it stays 0 from the final byte until mac_done_i.
- R7: wmark_o is 1 exactly when FIFO occupancy is at least three quarters of DEPTH (6 of 8 by default).
- R8: A write that arrives while the FIFO holds DEPTH words is dropped and leaves no trace in any later frame.
- R9: A mac_done_i pulse while the block waits for an outcome sets done_o and loads tx_stat_o from mac_stat_i. The status layout is: bit 0 sent OK, bit 1 deferred, bit 2 late collision, bit 3 excessive collisions, bit 4 excessive deferral, bit 5 underrun, bit 6 oversize frame, bits 10:7 collision count. A mac_done_i pulse at any other time changes nothing.
- R10: A write with st_wr_i=1 and st_wdata_i=1 clears done_o. A write with st_wdata_i=0 has no effect. If the set and the clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host word write strobe |
| wr_last_i | input | 1 | 1 selects the end-of-frame address, which commits the frame |
| wr_data_i | input | 32 | Word data; first byte in bits 7:0 |
| wr_bytes_i | input | 2 | Valid lanes in the end-of-frame word, 0 means 4 |
| tx_empty_o | output | 1 | Ready for a new frame |
| wmark_o | output | 1 | FIFO occupancy at or above three quarters |
| tx_valid_o | output | 1 | Byte available to the MAC |
| tx_data_o | output | 8 | Byte to the MAC |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | MAC accepts the byte |
| mac_done_i | input | 1 | MAC reports the frame outcome |
| mac_stat_i | input | 11 | Outcome flags and collision count from the MAC |
| st_wr_i | input | 1 | Host write to the completion bit |
| st_wdata_i | input | 1 | Write data; 1 clears the completion bit |
| done_o | output | 1 | Sticky completion bit |
| tx_stat_o | output | 11 | Latched transmit status |

## Verification
The completion bit can be set by the MAC's outcome pulse and cleared by a host write in the same cycle. The bench drives mac_done_i together with a one-valued status write and expects done_o to read 1 afterwards; later writes must then clear it, or leave it alone when the data is zero. The FIFO can also be pushed and popped on one edge. The bench fills the FIFO with a full committed frame and issues one more write on the edge where the first word is popped. It then requires that the extra word never shows up: the block returns to empty after the frame, and the next frame carries only its own bytes.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(BYTES);
  localparam int CNT_W  = LANE_W + 1;
  localparam int STAT_W = 11;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              last;
    logic [LANE_W-1:0] nbytes;
  } txf_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } txf_state_e;
endpackage

// File: rtl/txf_fifo.sv
module txf_fifo
  import txf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  txf_entry_t push_data_i,
  input  logic       pop_i,
  output txf_entry_t head_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       wmark_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int WMARK = (DEPTH * 3) / 4;

  txf_entry_t      mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]   cnt_q;
  logic            push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wmark_o = (cnt_q >= CW'(WMARK));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R8: a push into a full FIFO without a pop must not change occupancy
  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(wr_ptr_q));

  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !push_i |=> empty_o);
endmodule

// File: rtl/txf_serializer.sv
module txf_serializer
  import txf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  txf_entry_t        head_i,
  input  logic              empty_i,
  input  logic              commit_i,
  input  logic              tx_ready_i,
  input  logic              mac_done_i,
  output logic              pop_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_last_o,
  output logic              idle_o,
  output logic              take_o
);
  localparam int FW = $clog2(DEPTH + 1);

  txf_state_e        st_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_q;
  logic [FW-1:0]     frames_q;
  logic              final_byte;

  function automatic logic [CNT_W-1:0] lanes(input txf_entry_t e);
    if (!e.last || e.nbytes == '0) return CNT_W'(BYTES);
    return CNT_W'(e.nbytes);
  endfunction

  assign final_byte = (cnt_q == CNT_W'(1));

  always_comb begin
    pop_o = 1'b0;
    case (st_q)
      ST_IDLE:  pop_o = (frames_q != '0) && !empty_i;
      ST_SEND:  pop_o = tx_ready_i && final_byte && !last_q && !empty_i;
      ST_FETCH: pop_o = !empty_i;
      default:  pop_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      word_q   <= '0;
      cnt_q    <= '0;
      last_q   <= 1'b0;
      frames_q <= '0;
    end else begin
      frames_q <= frames_q + FW'(commit_i) - FW'(pop_o && head_i.last);
      if (pop_o) begin
        word_q <= head_i.word;
        cnt_q  <= lanes(head_i);
        last_q <= head_i.last;
      end
      case (st_q)
        ST_IDLE:  if (pop_o) st_q <= ST_SEND;
        ST_SEND: begin
          if (tx_ready_i) begin
            if (final_byte) begin
              if (last_q)      st_q <= ST_WAIT;
              else if (!pop_o) st_q <= ST_FETCH;
            end else begin
              word_q <= word_q >> BYTE_W;
              cnt_q  <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_FETCH: if (pop_o) st_q <= ST_SEND;
        ST_WAIT:  if (mac_done_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (st_q == ST_SEND);
  assign tx_data_o  = word_q[BYTE_W-1:0];
  assign tx_last_o  = (st_q == ST_SEND) && final_byte && last_q;
  assign idle_o     = (st_q == ST_IDLE);
  assign take_o     = (st_q == ST_WAIT) && mac_done_i;

  // R5: stalled byte holds
  a_r5_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R4: nothing follows the final byte until the outcome arrives
  a_r4_last_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o && tx_ready_i |=> !tx_valid_o);
endmodule

// File: rtl/txf_status.sv
module txf_status
  import txf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [STAT_W-1:0] mac_stat_i,
  input  logic              st_wr_i,
  input  logic              st_wdata_i,
  output logic              done_o,
  output logic [STAT_W-1:0] stat_o
);
  logic              done_q;
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      stat_q <= '0;
    end else begin
      if (take_i) begin
        done_q <= 1'b1;
        stat_q <= mac_stat_i;
      end else if (st_wr_i && st_wdata_i) begin
        done_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign stat_o = stat_q;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> done_o);

  a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr_i && st_wdata_i && !take_i |=> !done_o);

  a_r10_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_wr_i && st_wdata_i) && !take_i |=> $stable(done_o));

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> stat_o == $past(mac_stat_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(stat_o));
endmodule

// File: rtl/tx_frame_loader.sv
module tx_frame_loader
  import txf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_last_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [LANE_W-1:0] wr_bytes_i,
  output logic              tx_empty_o,
  output logic              wmark_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  input  logic              mac_done_i,
  input  logic [STAT_W-1:0] mac_stat_i,
  input  logic              st_wr_i,
  input  logic              st_wdata_i,
  output logic              done_o,
  output logic [STAT_W-1:0] tx_stat_o
);
  txf_entry_t wr_entry, head;
  logic       fifo_empty, fifo_full, pop, commit, idle, take;

  assign wr_entry = '{word: wr_data_i, last: wr_last_i, nbytes: wr_bytes_i};
  assign commit   = wr_en_i && wr_last_i && !fifo_full;

  txf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_en_i),
    .push_data_i (wr_entry),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full),
    .wmark_o     (wmark_o)
  );

  txf_serializer #(.DEPTH(DEPTH)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_i     (head),
    .empty_i    (fifo_empty),
    .commit_i   (commit),
    .tx_ready_i (tx_ready_i),
    .mac_done_i (mac_done_i),
    .pop_o      (pop),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .idle_o     (idle),
    .take_o     (take)
  );

  txf_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .mac_stat_i (mac_stat_i),
    .st_wr_i    (st_wr_i),
    .st_wdata_i (st_wdata_i),
    .done_o     (done_o),
    .stat_o     (tx_stat_o)
  );

  assign tx_empty_o = fifo_empty && idle;

  // R6: a byte on the wire means the block is not empty
  a_r6_busy_when_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !tx_empty_o);

  a_r6_accepted_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !fifo_full |=> !tx_empty_o);
endmodule

// File: tb/tb_tx_frame_loader.sv
module tb_tx_frame_loader;
  localparam int DEPTH = 8;
  localparam int NV = 6;
  localparam int VLEN  [NV] = '{1, 4, 5, 7, 13, 30};
  localparam int VSEED [NV] = '{8'h11, 8'h20, 8'hA0, 8'h31, 8'hC5, 8'h02};
  localparam int VSTAT [NV] = '{11'h001, 11'h003, 11'h104, 11'h788, 11'h010, 11'h060};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 0, wr_last = 0, tx_ready = 1, mac_done = 0, st_wr = 0, st_wdata = 0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_bytes = '0;
  logic [10:0] mac_stat = '0;
  logic        tx_empty, wmark, tx_valid, tx_last, done;
  logic [7:0]  tx_data;
  logic [10:0] tx_stat;

  tx_frame_loader #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_last_i(wr_last),
    .wr_data_i(wr_data), .wr_bytes_i(wr_bytes), .tx_empty_o(tx_empty),
    .wmark_o(wmark), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .mac_done_i(mac_done),
    .mac_stat_i(mac_stat), .st_wr_i(st_wr), .st_wdata_i(st_wdata),
    .done_o(done), .tx_stat_o(tx_stat)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] exp_b [64];
  logic [7:0] got_b [64];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mkword(input int w, input int len);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (w * 4 + k < len) r[k*8 +: 8] = exp_b[w*4+k];
    return r;
  endfunction

  task automatic set_frame(input int len, input int seed);
    for (int i = 0; i < 64; i++) exp_b[i] = 8'(seed + i);
  endtask

  task automatic wr(input logic [31:0] d, input logic l, input logic [1:0] nb);
    wr_en = 1; wr_last = l; wr_data = d; wr_bytes = nb;
    @(negedge clk);
    wr_en = 0; wr_last = 0;
  endtask

  // R2: hold back end-of-frame write for gap cycles and watch the byte port
  task automatic load(input int len, input int seed, input int gap);
    int nw = (len + 3) / 4;
    int early = 0;
    set_frame(len, seed);
    for (int w = 0; w < nw; w++) begin
      if (w == nw - 1) begin
        for (int g = 0; g < gap; g++) begin
          if (tx_valid) early++;
          @(negedge clk);
        end
        if (gap > 0) chk(early == 0 && !tx_valid, "R2 no byte before commit", early, 0);
        wr(mkword(w, len), 1'b1, 2'(len % 4));
      end else begin
        wr(mkword(w, len), 1'b0, 2'd0);
      end
    end
  endtask

  task automatic collect(input int len, input bit stall);
    int n = 0, t = 0, bad_last = 0, bad_b = 0, bad_hold = 0, first_bad = -1;
    bit prev_stall = 0;
    logic [7:0] held = '0;
    while (n < len && t < 2000) begin
      tx_ready = stall ? t[0] : 1'b1;
      #1;
      if (prev_stall && tx_data != held) bad_hold++;
      prev_stall = tx_valid && !tx_ready;
      held = tx_data;
      if (tx_valid && tx_ready) begin
        got_b[n] = tx_data;
        if (tx_last != (n == len - 1)) bad_last++;
        n++;
      end
      @(negedge clk);
      t++;
    end
    tx_ready = 1;
    for (int j = 0; j < len; j++)
      if (got_b[j] != exp_b[j]) begin
        bad_b++;
        if (first_bad < 0) first_bad = j;
      end
    chk(n == len, "R4 byte count", n, len);
    chk(bad_b == 0, "R3 byte order", (first_bad < 0) ? 0 : got_b[first_bad],
        (first_bad < 0) ? 0 : exp_b[first_bad]);
    chk(bad_last == 0, "R4 last flag", bad_last, 0);
    if (stall) chk(bad_hold == 0, "R5 hold while stalled", bad_hold, 0);
    chk(!tx_valid && !tx_empty, "R6 waiting for outcome", {tx_valid, tx_empty}, 2'b00);
  endtask

  task automatic outcome(input logic [10:0] s, input bit clr_same);
    mac_stat = s; mac_done = 1;
    st_wr = clr_same; st_wdata = clr_same;
    @(negedge clk);
    mac_done = 0; st_wr = 0; st_wdata = 0;
    chk(done == 1'b1, clr_same ? "R10 set wins" : "R9 done set", done, 1);
    chk(tx_stat == s, "R9 status latched", tx_stat, s);
    chk(tx_empty == 1'b1, "R6 empty after outcome", tx_empty, 1);
  endtask

  task automatic clear();
    st_wr = 1; st_wdata = 1;
    @(negedge clk);
    st_wr = 0; st_wdata = 0;
    chk(done == 1'b0, "R10 write one clears", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({tx_empty, tx_valid, done, wmark, tx_stat} == {4'b1000, 11'h0}, "R1 in reset",
        {tx_empty, tx_valid, done, wmark, tx_stat}, {4'b1000, 11'h0});
    rst_n = 1;
    @(negedge clk);
    chk({tx_empty, tx_valid, done, wmark, tx_stat} == {4'b1000, 11'h0}, "R1 after reset",
        {tx_empty, tx_valid, done, wmark, tx_stat}, {4'b1000, 11'h0});

    for (int i = 0; i < NV; i++) begin
      load(VLEN[i], VSEED[i], (i == 2) ? 6 : 0);
      collect(VLEN[i], i == 4);
      outcome(11'(VSTAT[i]), 1'b0);
      clear();
    end

    // R6 and R7: occupancy and watermark, frame of 27 bytes
    set_frame(27, 8'h50);
    wr(mkword(0, 27), 1'b0, 2'd0);
    chk(!tx_empty, "R6 not empty after write", tx_empty, 0);
    for (int w = 1; w < 5; w++) wr(mkword(w, 27), 1'b0, 2'd0);
    chk(!wmark && !tx_valid, "R7 below watermark at 5", wmark, 0);
    wr(mkword(5, 27), 1'b0, 2'd0);
    chk(wmark, "R7 watermark at 6", wmark, 1);
    wr(mkword(6, 27), 1'b1, 2'd3);
    collect(27, 1'b0);
    outcome(11'h081, 1'b0);
    clear();

    // R8: full FIFO, extra write on the pop edge is dropped
    set_frame(32, 8'h40);
    for (int w = 0; w < 7; w++) wr(mkword(w, 32), 1'b0, 2'd0);
    wr(mkword(7, 32), 1'b1, 2'd0);
    wr(32'hDEAD_BEEF, 1'b0, 2'd0);
    collect(32, 1'b0);
    outcome(11'h001, 1'b0);
    chk(tx_empty, "R8 dropped word not stored", tx_empty, 1);
    clear();
    load(2, 8'h90, 0);
    collect(2, 1'b0);
    outcome(11'h002, 1'b0);
    clear();

    // R9: outcome pulse while idle is ignored
    mac_stat = 11'h7FF; mac_done = 1;
    @(negedge clk);
    mac_done = 0;
    chk(!done && tx_stat == 11'h002, "R9 idle pulse ignored", {done, tx_stat}, {1'b0, 11'h002});

    // R10: same-cycle set and clear, then zero write, then clear
    load(3, 8'hE0, 0);
    collect(3, 1'b0);
    outcome(11'h205, 1'b1);
    st_wr = 1; st_wdata = 0;
    @(negedge clk);
    st_wr = 0;
    chk(done, "R10 zero write no effect", done, 1);
    clear();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule